// File: doc/BRIEF.md
# Byte/Word Flag-Updating ALU

This block is the arithmetic and logic datapath of a small CPU whose register file holds 8-bit registers that pair up into 16-bit words. It is purely combinational: an operation code, a destination operand, a source operand and the current condition-code byte go in. The result, the new condition-code byte and a write-back qualifier come out in the same cycle. Register-file access, instruction decoding and multi-cycle arithmetic stay outside the block.

The defining property of the block is selective flag update. Each operation rewrites only the condition-code bits it owns and passes every other bit through unchanged. For example, increment keeps the carry, and the chained add and subtract can clear the zero flag but never set it. The word step operations (plus or minus 1 or 2) touch no flag at all. The decode stage feeds the incoming condition-code byte straight through and stores whatever the block returns.

Top module: `fc_alu`

## Requirements
- R1: Increment (op 0) and decrement (op 1) act on the low byte of the destination. N is result bit 7, and Z is set when the result is zero. V is set only when the operand was 0x7F for increment or 0x80 for decrement, and is cleared otherwise. H (bit 5) and C (bit 0) are left unchanged.
- R2: Byte add (op 2), subtract (op 4) and negate (op 7, computed as 0 minus the destination byte) update all five arithmetic flags. H is the carry or borrow out of bit 3. C is the carry or borrow out of bit 7. V is two's-complement overflow. N and Z follow the result.
- R3: Word add (op 12) and subtract (op 13) use the full 16-bit operands. H is the carry or borrow out of bit 11, C is the carry or borrow out of bit 15, and V is 16-bit signed overflow.
- R4: Add-with-carry (op 3) and subtract-with-carry (op 5) use the incoming C as carry-in or borrow-in. A nonzero result clears Z, and a zero result leaves Z as it was. H, C, V and N are set as for R2.
- R5: Byte compare (op 6) and word compare (op 14) set flags exactly as byte or word subtract of source from destination would. They drive the difference on the result port with the write-back qualifier low.
- R6: AND (op 8), OR (op 9), XOR (op 10) and NOT of the destination (op 11) set N and Z from the byte result and clear V. H and C are left unchanged.
- R7: Word step ops add 1 (op 15), add 2 (op 16), subtract 1 (op 17) or subtract 2 (op 18) to the 16-bit destination, wrapping modulo 65536. The condition-code byte is returned unchanged.
- R8: The condition-code byte is laid out as I=bit 7, unused bits 6 and 4, H=5, N=3, Z=2, V=1, C=0. Bits 7, 6 and 4 are never altered. Every byte result has its upper byte zero. The write-back qualifier is high for every defined op except the compares.
- R9: Op codes 19 to 31 are undefined. For these, the result equals the destination operand, the condition-code byte is returned unchanged, and the write-back qualifier is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| dst_i | input | 16 | Destination operand (byte ops use bits 7:0) |
| src_i | input | 16 | Source operand (byte ops use bits 7:0) |
| ccr_i | input | 8 | Current condition-code byte |
| res_o | output | 16 | Operation result |
| ccr_o | output | 8 | Updated condition-code byte |
| wb_o | output | 1 | High when the result is to be written back |

## Verification
Every output is due in the same cycle as its inputs, with zero register stages between any input and any output. The bench applies a new operation one time unit after a rising clock edge and compares result, flags and write-back at the following falling edge. This leaves half a period for the logic to settle and keeps input changes and sampling apart. The directed table covers each flag boundary: 0x7F/0x80 overflow, nibble and bit-11 carries, a zero result under chained ops with Z both set and clear, and undefined codes. A random phase then compares every op against an arithmetic model built from wide signed and unsigned integer sums.

// File: rtl/fc_alu_pkg.sv
package fc_alu_pkg;

  localparam int unsigned CCR_W = 8;

  // flag bit positions, decoded by branch logic outside this block
  localparam int unsigned FB_C = 0;
  localparam int unsigned FB_V = 1;
  localparam int unsigned FB_Z = 2;
  localparam int unsigned FB_N = 3;
  localparam int unsigned FB_H = 5;

  localparam logic [CCR_W-1:0] MASK_NZV   = CCR_W'((1 << FB_N) | (1 << FB_Z) | (1 << FB_V));
  localparam logic [CCR_W-1:0] MASK_ARITH = CCR_W'((1 << FB_H) | (1 << FB_N) | (1 << FB_Z)
                                                   | (1 << FB_V) | (1 << FB_C));

  typedef enum logic [4:0] {
    OP_INC_B   = 5'd0,
    OP_DEC_B   = 5'd1,
    OP_ADD_B   = 5'd2,
    OP_ADDC_B  = 5'd3,
    OP_SUB_B   = 5'd4,
    OP_SUBC_B  = 5'd5,
    OP_CMP_B   = 5'd6,
    OP_NEG_B   = 5'd7,
    OP_AND_B   = 5'd8,
    OP_OR_B    = 5'd9,
    OP_XOR_B   = 5'd10,
    OP_NOT_B   = 5'd11,
    OP_ADD_W   = 5'd12,
    OP_SUB_W   = 5'd13,
    OP_CMP_W   = 5'd14,
    OP_INC1_W  = 5'd15,
    OP_INC2_W  = 5'd16,
    OP_DEC1_W  = 5'd17,
    OP_DEC2_W  = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } lg_sel_e;

  function automatic logic [CCR_W-1:0] pack_flags(input logic h, input logic n, input logic z,
                                                  input logic v, input logic c);
    logic [CCR_W-1:0] f;
    f       = '0;
    f[FB_H] = h;
    f[FB_N] = n;
    f[FB_Z] = z;
    f[FB_V] = v;
    f[FB_C] = c;
    return f;
  endfunction

endpackage

// File: rtl/fc_addsub.sv
module fc_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         half_o,
  output logic         ovf_o
);
  // half-carry is taken out of the nibble below the top nibble
  localparam int unsigned HB = W - 4;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [HB:0]  low;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? ~cin_i : cin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, a_i[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
  end

  assign sum_o   = full[W-1:0];
  assign carry_o = full[W] ^ sub_i;
  assign half_o  = low[HB] ^ sub_i;
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);

endmodule

// File: rtl/fc_logic.sv
module fc_logic
  import fc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (lg_sel_e'(sel_i))
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/fc_alu.sv
module fc_alu
  import fc_alu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic [4:0]        op_i,
  input  logic [WORD_W-1:0] dst_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic [CCR_W-1:0]  ccr_i,
  output logic [WORD_W-1:0] res_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic              wb_o
);
  localparam int unsigned EXT_W = WORD_W - BYTE_W;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // byte adder controls and results
  logic [BYTE_W-1:0] b_a, b_b, b_sum;
  logic              b_cin, b_sub, b_c, b_h, b_v;
  // word adder controls and results
  logic [WORD_W-1:0] w_b, w_sum;
  logic              w_sub, w_c, w_h, w_v;
  // logic unit
  logic [1:0]        lg_sel;
  logic [BYTE_W-1:0] lg_y;
  // composed outputs
  logic [WORD_W-1:0] b_res, l_res, res_d;
  logic [CCR_W-1:0]  flg_new, flg_mask;
  logic              wb_d;
  logic              b_zero, w_zero, l_zero;

  // operand steering for the two adders and the logic unit
  always_comb begin
    b_a    = dst_i[BYTE_W-1:0];
    b_b    = src_i[BYTE_W-1:0];
    b_cin  = 1'b0;
    b_sub  = 1'b0;
    w_b    = src_i;
    w_sub  = 1'b0;
    lg_sel = 2'(LG_AND);
    unique case (op)
      OP_INC_B:  b_b = BYTE_W'(1);
      OP_DEC_B:  begin b_b = BYTE_W'(1); b_sub = 1'b1; end
      OP_ADDC_B: b_cin = ccr_i[FB_C];
      OP_SUB_B,
      OP_CMP_B:  b_sub = 1'b1;
      OP_SUBC_B: begin b_sub = 1'b1; b_cin = ccr_i[FB_C]; end
      OP_NEG_B:  begin b_a = '0; b_b = dst_i[BYTE_W-1:0]; b_sub = 1'b1; end
      OP_OR_B:   lg_sel = 2'(LG_OR);
      OP_XOR_B:  lg_sel = 2'(LG_XOR);
      OP_NOT_B:  lg_sel = 2'(LG_NOT);
      OP_SUB_W,
      OP_CMP_W:  w_sub = 1'b1;
      OP_INC1_W: w_b = WORD_W'(1);
      OP_INC2_W: w_b = WORD_W'(2);
      OP_DEC1_W: begin w_b = WORD_W'(1); w_sub = 1'b1; end
      OP_DEC2_W: begin w_b = WORD_W'(2); w_sub = 1'b1; end
      default: ;
    endcase
  end

  fc_addsub #(.W(BYTE_W)) u_badd (
    .a_i(b_a), .b_i(b_b), .cin_i(b_cin), .sub_i(b_sub),
    .sum_o(b_sum), .carry_o(b_c), .half_o(b_h), .ovf_o(b_v)
  );

  fc_addsub #(.W(WORD_W)) u_wadd (
    .a_i(dst_i), .b_i(w_b), .cin_i(1'b0), .sub_i(w_sub),
    .sum_o(w_sum), .carry_o(w_c), .half_o(w_h), .ovf_o(w_v)
  );

  fc_logic #(.W(BYTE_W)) u_logic (
    .sel_i(lg_sel), .a_i(dst_i[BYTE_W-1:0]), .b_i(src_i[BYTE_W-1:0]), .y_o(lg_y)
  );

  // byte results are zero-extended to the result width
  generate
    if (EXT_W > 0) begin : g_ext
      assign b_res = {{EXT_W{1'b0}}, b_sum};
      assign l_res = {{EXT_W{1'b0}}, lg_y};
    end else begin : g_noext
      assign b_res = b_sum;
      assign l_res = lg_y;
    end
  endgenerate

  assign b_zero = (b_sum == '0);
  assign w_zero = (w_sum == '0);
  assign l_zero = (lg_y == '0);

  // per-op result selection and flag ownership
  always_comb begin
    res_d    = dst_i;
    wb_d     = 1'b0;
    flg_new  = '0;
    flg_mask = '0;
    unique case (op)
      OP_INC_B, OP_DEC_B: begin
        res_d    = b_res;
        wb_d     = 1'b1;
        flg_new  = pack_flags(1'b0, b_sum[BYTE_W-1], b_zero, b_v, 1'b0);
        flg_mask = MASK_NZV;
      end
      OP_ADD_B, OP_SUB_B, OP_NEG_B, OP_CMP_B: begin
        res_d    = b_res;
        wb_d     = (op != OP_CMP_B);
        flg_new  = pack_flags(b_h, b_sum[BYTE_W-1], b_zero, b_v, b_c);
        flg_mask = MASK_ARITH;
      end
      OP_ADDC_B, OP_SUBC_B: begin
        res_d    = b_res;
        wb_d     = 1'b1;
        flg_new  = pack_flags(b_h, b_sum[BYTE_W-1], b_zero & ccr_i[FB_Z], b_v, b_c);
        flg_mask = MASK_ARITH;
      end
      OP_AND_B, OP_OR_B, OP_XOR_B, OP_NOT_B: begin
        res_d    = l_res;
        wb_d     = 1'b1;
        flg_new  = pack_flags(1'b0, lg_y[BYTE_W-1], l_zero, 1'b0, 1'b0);
        flg_mask = MASK_NZV;
      end
      OP_ADD_W, OP_SUB_W, OP_CMP_W: begin
        res_d    = w_sum;
        wb_d     = (op != OP_CMP_W);
        flg_new  = pack_flags(w_h, w_sum[WORD_W-1], w_zero, w_v, w_c);
        flg_mask = MASK_ARITH;
      end
      OP_INC1_W, OP_INC2_W, OP_DEC1_W, OP_DEC2_W: begin
        res_d = w_sum;
        wb_d  = 1'b1;
      end
      default: ;
    endcase
  end

  assign res_o = res_d;
  assign wb_o  = wb_d;
  assign ccr_o = (ccr_i & ~flg_mask) | (flg_new & flg_mask);

endmodule

// File: rtl/fc_alu_chk.sv
module fc_alu_chk
  import fc_alu_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input logic [4:0]        op_i,
  input logic [WORD_W-1:0] dst_i,
  input logic [CCR_W-1:0]  ccr_i,
  input logic [WORD_W-1:0] res_o,
  input logic [CCR_W-1:0]  ccr_o,
  input logic              wb_o
);
  always_comb begin
    a_r8_reserved_kept: assert (ccr_o[7] == ccr_i[7] && ccr_o[6] == ccr_i[6] && ccr_o[4] == ccr_i[4])
      else $error("I or unused flag bits altered");

    if (op_i == OP_INC_B || op_i == OP_DEC_B) begin
      a_r1_step_keeps_hc: assert (ccr_o[FB_H] == ccr_i[FB_H] && ccr_o[FB_C] == ccr_i[FB_C])
        else $error("increment/decrement altered H or C");
    end

    if (op_i == OP_ADDC_B || op_i == OP_SUBC_B) begin
      a_r4_z_never_set: assert (!ccr_o[FB_Z] || ccr_i[FB_Z])
        else $error("chained op set Z");
    end

    if (op_i == OP_CMP_B || op_i == OP_CMP_W) begin
      a_r5_cmp_no_write: assert (!wb_o) else $error("compare requested write-back");
    end

    if (op_i >= OP_AND_B && op_i <= OP_NOT_B) begin
      a_r6_logic_flags: assert (!ccr_o[FB_V] && ccr_o[FB_H] == ccr_i[FB_H] && ccr_o[FB_C] == ccr_i[FB_C])
        else $error("logic op flag rule broken");
    end

    if (op_i >= OP_INC1_W && op_i <= OP_DEC2_W) begin
      a_r7_word_step_flags: assert (ccr_o == ccr_i) else $error("word step changed flags");
    end

    if (op_i > OP_DEC2_W) begin
      a_r9_undef_pass: assert (res_o == dst_i && ccr_o == ccr_i && !wb_o)
        else $error("undefined op not passed through");
    end
  end
endmodule

bind fc_alu fc_alu_chk #(.WORD_W(WORD_W)) u_chk (
  .op_i(op_i), .dst_i(dst_i), .ccr_i(ccr_i),
  .res_o(res_o), .ccr_o(ccr_o), .wb_o(wb_o)
);

// File: tb/sim_fc_alu.sv
module sim_fc_alu;
  localparam int CLK_P   = 10;
  localparam int N_VEC   = 26;
  localparam int N_RAND  = 3000;

  logic        clk;
  logic        rst_n;
  logic [4:0]  op;
  logic [15:0] dst, src, res;
  logic [7:0]  ccr_in, ccr_out;
  logic        wb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  fc_alu u0 (
    .op_i(op), .dst_i(dst), .src_i(src), .ccr_i(ccr_in),
    .res_o(res), .ccr_o(ccr_out), .wb_o(wb)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {op, dst, src, ccr_in, exp_res, exp_ccr, exp_wb}
  localparam logic [69:0] VEC [N_VEC] = '{
    {5'd0,  16'hAB7F, 16'h0000, 8'h21, 16'h0080, 8'h2B, 1'b1}, // R1 0x7F overflow, upper byte zero
    {5'd0,  16'h00FF, 16'h0000, 8'h00, 16'h0000, 8'h04, 1'b1}, // R1 wrap to zero
    {5'd1,  16'h0080, 16'h0000, 8'hC0, 16'h007F, 8'hC2, 1'b1}, // R1 0x80 overflow, R8 I/U kept
    {5'd2,  16'h000F, 16'h0001, 8'h00, 16'h0010, 8'h20, 1'b1}, // R2 nibble carry
    {5'd2,  16'h0080, 16'h0080, 8'h00, 16'h0000, 8'h07, 1'b1}, // R2 carry+overflow
    {5'd3,  16'h00FF, 16'h0000, 8'h05, 16'h0000, 8'h25, 1'b1}, // R4 zero keeps Z=1
    {5'd3,  16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h00, 1'b1}, // R4 zero keeps Z=0
    {5'd5,  16'h0010, 16'h000F, 8'h05, 16'h0000, 8'h24, 1'b1}, // R4 borrow-in
    {5'd4,  16'h0000, 16'h0001, 8'h00, 16'h00FF, 8'h29, 1'b1}, // R2 borrow
    {5'd6,  16'h0005, 16'h0005, 8'h0B, 16'h0000, 8'h04, 1'b0}, // R5 byte compare equal
    {5'd7,  16'h0080, 16'h0000, 8'h00, 16'h0080, 8'h0B, 1'b1}, // R2 negate 0x80
    {5'd7,  16'h0000, 16'h0000, 8'h29, 16'h0000, 8'h04, 1'b1}, // R2 negate zero
    {5'd8,  16'h00F0, 16'h000F, 8'h23, 16'h0000, 8'h25, 1'b1}, // R6 and
    {5'd9,  16'h0080, 16'h0001, 8'h06, 16'h0081, 8'h08, 1'b1}, // R6 or
    {5'd10, 16'h00AA, 16'h00AA, 8'h08, 16'h0000, 8'h04, 1'b1}, // R6 xor
    {5'd11, 16'h557F, 16'h0000, 8'h00, 16'h0080, 8'h08, 1'b1}, // R6 not
    {5'd12, 16'h0FFF, 16'h0001, 8'h00, 16'h1000, 8'h20, 1'b1}, // R3 bit-11 carry
    {5'd12, 16'h7FFF, 16'h0001, 8'h00, 16'h8000, 8'h2A, 1'b1}, // R3 overflow
    {5'd13, 16'h1000, 16'h0001, 8'h00, 16'h0FFF, 8'h20, 1'b1}, // R3 bit-11 borrow
    {5'd14, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h29, 1'b0}, // R5 word compare
    {5'd16, 16'hFFFF, 16'h0000, 8'hAA, 16'h0001, 8'hAA, 1'b1}, // R7 add 2 wrap
    {5'd17, 16'h0000, 16'h0000, 8'h55, 16'hFFFF, 8'h55, 1'b1}, // R7 sub 1 wrap
    {5'd15, 16'h1234, 16'h0000, 8'h00, 16'h1235, 8'h00, 1'b1}, // R7 add 1
    {5'd18, 16'h0001, 16'h0000, 8'hFF, 16'hFFFF, 8'hFF, 1'b1}, // R7 sub 2
    {5'd31, 16'h1234, 16'h5678, 8'hC3, 16'h1234, 8'hC3, 1'b0}, // R9 top code
    {5'd19, 16'hABCD, 16'h0000, 8'h3C, 16'hABCD, 8'h3C, 1'b0}  // R9 first undefined
  };

  localparam string TAG [N_VEC] = '{
    "R1", "R1", "R1", "R2", "R2", "R4", "R4", "R4", "R2", "R5", "R2", "R2", "R6",
    "R6", "R6", "R6", "R3", "R3", "R3", "R5", "R7", "R7", "R7", "R7", "R9", "R9"
  };

  task automatic check(input string tag, input string what, input logic [15:0] got,
                       input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d dst=%h src=%h ccr=%h: actual %h expected %h",
               tag, what, op, dst, src, ccr_in, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] o, input logic [15:0] d, input logic [15:0] s,
                       input logic [7:0] f);
    @(posedge clk);
    #1;
    op = o; dst = d; src = s; ccr_in = f;
    @(negedge clk);
  endtask

  // {h, c, v, result[15:0]} from plain integer arithmetic
  function automatic logic [18:0] arith(input int a, input int b, input int ci,
                                        input bit sub, input int w);
    int m, hm, raw, hraw, sa, sb, sr;
    bit h, c, v;
    m    = (1 << w) - 1;
    hm   = (1 << (w - 4)) - 1;
    raw  = sub ? a - b - ci : a + b + ci;
    hraw = sub ? (a & hm) - (b & hm) - ci : (a & hm) + (b & hm) + ci;
    c    = sub ? (raw < 0) : (raw > m);
    h    = sub ? (hraw < 0) : (hraw > hm);
    sa   = (a > (m >> 1)) ? a - (m + 1) : a;
    sb   = (b > (m >> 1)) ? b - (m + 1) : b;
    sr   = sub ? sa - sb - ci : sa + sb + ci;
    v    = (sr > (m >> 1)) || (sr < -((m + 1) >> 1));
    return {h, c, v, 16'(raw & m)};
  endfunction

  // {wb, res[15:0], ccr[7:0]}
  function automatic logic [24:0] model(input logic [4:0] o, input logic [15:0] d,
                                        input logic [15:0] s, input logic [7:0] f);
    logic [18:0] r;
    logic [15:0] rs;
    logic [7:0]  nf;
    bit          w;
    int          a, b, ci;
    bit          sb;
    nf = f; rs = d; w = 0;
    if (o <= 5'd7) begin
      a = int'(d[7:0]); b = int'(s[7:0]); ci = 0; sb = 0;
      case (o)
        5'd0: b = 1;
        5'd1: begin b = 1; sb = 1; end
        5'd3: ci = int'(f[0]);
        5'd4, 5'd6: sb = 1;
        5'd5: begin sb = 1; ci = int'(f[0]); end
        5'd7: begin a = 0; b = int'(d[7:0]); sb = 1; end
        default: ;
      endcase
      r = arith(a, b, ci, sb, 8);
      rs = r[15:0];
      w = (o != 5'd6);
      nf[3] = r[7];
      nf[1] = r[16];
      if (o <= 5'd1) nf[2] = (r[7:0] == 0);
      else begin
        nf[5] = r[18];
        nf[0] = r[17];
        nf[2] = (o == 5'd3 || o == 5'd5) ? (f[2] && r[7:0] == 0) : (r[7:0] == 0);
      end
    end else if (o <= 5'd11) begin
      case (o)
        5'd8:    rs = {8'h00, d[7:0] & s[7:0]};
        5'd9:    rs = {8'h00, d[7:0] | s[7:0]};
        5'd10:   rs = {8'h00, d[7:0] ^ s[7:0]};
        default: rs = {8'h00, ~d[7:0]};
      endcase
      w = 1;
      nf[3] = rs[7]; nf[2] = (rs == 0); nf[1] = 0;
    end else if (o <= 5'd14) begin
      r = arith(int'(d), int'(s), 0, o != 5'd12, 16);
      rs = r[15:0];
      w = (o != 5'd14);
      nf[5] = r[18]; nf[3] = r[15]; nf[2] = (r[15:0] == 0); nf[1] = r[16]; nf[0] = r[17];
    end else if (o <= 5'd18) begin
      case (o)
        5'd15:   rs = d + 16'd1;
        5'd16:   rs = d + 16'd2;
        5'd17:   rs = d - 16'd1;
        default: rs = d - 16'd2;
      endcase
      w = 1;
    end
    return {w, rs, nf};
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [24:0] e;
    logic [4:0]  ro;
    rst_n = 1'b0;
    op = 5'd0; dst = '0; src = '0; ccr_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // directed table
    for (int i = 0; i < N_VEC; i++) begin
      apply(VEC[i][69:65], VEC[i][64:49], VEC[i][48:33], VEC[i][32:25]);
      check(TAG[i], "result", res, VEC[i][24:9]);
      check(TAG[i], "flags", {8'h00, ccr_out}, {8'h00, VEC[i][8:1]});
      check(TAG[i], "write-back", {15'h0, wb}, {15'h0, VEC[i][0]});
    end

    // R8: every defined op with all flag bits set keeps bits 7, 6, 4
    for (int k = 0; k <= 18; k++) begin
      apply(5'(k), 16'hFF80, 16'h0080, 8'hFF);
      check("R8", "reserved bits", {13'h0, ccr_out[7], ccr_out[6], ccr_out[4]}, 16'h0007);
    end

    // random operands and incoming flags against the model
    for (int n = 0; n < N_RAND; n++) begin
      ro = 5'($urandom_range(0, 21));
      if (ro > 5'd18) ro = 5'($urandom_range(19, 31));
      apply(ro, 16'($urandom), 16'($urandom), 8'($urandom));
      e = model(op, dst, src, ccr_in);
      check("rand", "result", res, e[23:8]);
      check("rand", "flags", {8'h00, ccr_out}, {8'h00, e[7:0]});
      check("rand", "write-back", {15'h0, wb}, {15'h0, e[24]});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule